// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Programmable Wait Stretch

This block runs external memory read and write cycles for an 8-bit microcontroller. Each accepted request walks a fixed sequence of bus states: T1 (address and chip enable set up), T2 and T3 (strobe active), then an optional run of wait states, then T4 (strobe released). One bus state lasts one period of `clk`. The block is clocked at twice the bus clock, so a bus state is half a bus-clock period. A 3-bit software selection sets how many wait states are placed between T3 and T4, so that slow devices get more access time. Wait states come in pairs, named TW1 and TW2.

The address is decoded into three active-low chip enables. The region that the lowest enable covers depends on a mode input. Accesses flagged as internal still run T1 to T4 with no waits, but they leave every external strobe and chip enable idle. Running from the low-speed clock also removes all waits. Standby forces every chip enable high.

The named states are ST_IDLE, ST_T1, ST_T2, ST_T3, ST_TW1, ST_TW2, ST_T4 and ST_DONE. The transitions are:
- IDLE→T1 when a request is accepted.
- T1→T2 and T2→T3 unconditionally.
- T3→TW1 when wait pairs remain, otherwise T3→T4.
- TW1→TW2 unconditionally.
- TW2→TW1 when more than one pair remains, otherwise TW2→T4.
- T4→DONE.
- DONE→IDLE.

Top module: `ext_bus_ctrl`

## Requirements
- R1: For an external access on the fast clock, `wait_sel` value s (0..7) inserts 2·s wait states, so the active strobe is low for exactly 2+2·s cycles.
- R2: Address and chip enable are valid for T1 through T4, which is 4+2·s cycles. The strobe is high in T1 and in T4. RD and WR are never low together.
- R3: With `req_internal`=1 no waits are inserted, and `bus_ce_n`, `bus_rd_n` and `bus_wr_n` stay high and `bus_data_oe` stays 0 for the whole access.
- R4: With `clk_slow`=1 no waits are inserted, whatever `wait_sel` holds.
- R5: `bus_ce_n[1]` goes low for addresses 100000h–1FFFFFh and `bus_ce_n[2]` goes low for 200000h–2FFFFFh.
- R6: With `ce0_low_map`=0, `bus_ce_n[0]` covers 300000h–3FFFFFh. With `ce0_low_map`=1 it covers 000000h–00D7FFh and 010000h–0FFFFFh. An external address outside every region runs the cycle with all chip enables high.
- R7: While `standby`=1 every bit of `bus_ce_n` is high.
- R8: For external reads, `rd_data` takes `bus_data_in` on the edge that enters T4 and holds it afterwards.
- R9: For external writes, `bus_data_oe`=1 and `bus_data_out` equals the request's write data from T2 through T4, and `bus_data_oe`=0 in T1.
- R10: `done` is a one-cycle pulse in the cycle after T4. Requests arriving while `busy`=1 are ignored.
- R11: At most one chip enable is low at any time.
- R12: After reset the block is idle: `busy`=0, `done`=0, strobes and chip enables high, `bus_data_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-state clock (one period per bus state) |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | 22 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| req_internal | input | 1 | Access targets on-chip memory or registers |
| clk_slow | input | 1 | System runs from the low-speed oscillator |
| standby | input | 1 | Device is in a standby state |
| wait_sel | input | 3 | Wait selection, 2·value states |
| ce0_low_map | input | 1 | Chip-enable 0 region select |
| bus_data_in | input | 8 | External data bus input |
| bus_addr | output | 22 | External address bus |
| bus_ce_n | output | 3 | Active-low chip enables |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_data_out | output | 8 | External data bus output |
| bus_data_oe | output | 1 | Data bus output enable |
| rd_data | output | 8 | Captured read data |
| done | output | 1 | Access complete pulse |
| busy | output | 1 | Access in progress |

## Verification
The bench builds the block with its default parameters: a 22-bit address, 8-bit data and a 3-bit wait selection. With these values all eight wait lengths can be exercised, up to the 14-state stretch, along with both chip-enable-0 maps and every region boundary near 00D7FFh/00D800h. Read capture timing is tested by changing the input bus during T4, which exposes a capture taken one edge too late.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TW1,
        ST_TW2,
        ST_T4,
        ST_DONE
    } bus_state_e;

    localparam int NUM_CE = 3;
endpackage

// File: rtl/ebc_wait_calc.sv
module ebc_wait_calc #(
    parameter int WSEL_W = 3
) (
    input  logic [WSEL_W-1:0] wait_sel,
    input  logic              internal_acc,
    input  logic              slow_clk,
    output logic [WSEL_W-1:0] pairs
);
    // Each selection step adds one TW1/TW2 pair; suppressed entirely when
    // the access is on-chip or the slow oscillator is in use.
    always_comb begin
        if (internal_acc || slow_clk)
            pairs = '0;
        else
            pairs = wait_sel;
    end
endmodule

// File: rtl/ebc_region_dec.sv
module ebc_region_dec #(
    parameter int                ADDR_W  = 22,
    parameter logic [ADDR_W-1:0] HI0_LO  = 22'h300000,
    parameter logic [ADDR_W-1:0] HI0_HI  = 22'h3FFFFF,
    parameter logic [ADDR_W-1:0] LOA_LO  = 22'h000000,
    parameter logic [ADDR_W-1:0] LOA_HI  = 22'h00D7FF,
    parameter logic [ADDR_W-1:0] LOB_LO  = 22'h010000,
    parameter logic [ADDR_W-1:0] LOB_HI  = 22'h0FFFFF,
    parameter logic [ADDR_W-1:0] SEL1_LO = 22'h100000,
    parameter logic [ADDR_W-1:0] SEL1_HI = 22'h1FFFFF,
    parameter logic [ADDR_W-1:0] SEL2_LO = 22'h200000,
    parameter logic [ADDR_W-1:0] SEL2_HI = 22'h2FFFFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              internal_acc,
    input  logic              low_map,
    output logic [2:0]        ce_sel
);
    function automatic logic in_rng(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] lo,
                                    input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    logic hit0, hit1, hit2;

    always_comb begin
        if (low_map)
            hit0 = in_rng(addr, LOA_LO, LOA_HI) || in_rng(addr, LOB_LO, LOB_HI);
        else
            hit0 = in_rng(addr, HI0_LO, HI0_HI);
        hit1 = in_rng(addr, SEL1_LO, SEL1_HI);
        hit2 = in_rng(addr, SEL2_LO, SEL2_HI);
        if (internal_acc)
            ce_sel = 3'b000;
        else
            ce_sel = {hit2, hit1, hit0};
    end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
    import ebc_pkg::*;
#(
    parameter int WSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WSEL_W-1:0] pairs_in,
    output bus_state_e        state,
    output logic              enter_t4
);
    bus_state_e        state_q, state_d;
    logic [WSEL_W-1:0] pairs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pairs_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start)
                pairs_q <= pairs_in;
            else if (state_q == ST_TW2)
                pairs_q <= pairs_q - 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_T1;
            ST_T1:   state_d = ST_T2;
            ST_T2:   state_d = ST_T3;
            ST_T3:   state_d = (pairs_q != '0) ? ST_TW1 : ST_T4;
            ST_TW1:  state_d = ST_TW2;
            ST_TW2:  state_d = (pairs_q == 1) ? ST_T4 : ST_TW1;
            ST_T4:   state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    assign state    = state_q;
    assign enter_t4 = (state_d == ST_T4) && (state_q != ST_T4);

    assert_no_wait_skip_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T3 && pairs_q == '0) |=> (state_q == ST_T4));
    assert_wait_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TW1) |=> (state_q == ST_TW2));
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 8,
    parameter int WSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_internal,
    input  logic              clk_slow,
    input  logic              standby,
    input  logic [WSEL_W-1:0] wait_sel,
    input  logic              ce0_low_map,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [2:0]        bus_ce_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              busy
);
    bus_state_e        state;
    logic              enter_t4;
    logic              start;
    logic [WSEL_W-1:0] pairs;
    logic [2:0]        ce_sel_d;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              write_q;
    logic              internal_q;
    logic [2:0]        ce_sel_q;

    assign start = req_valid && (state == ST_IDLE);

    ebc_wait_calc #(.WSEL_W(WSEL_W)) u_wait (
        .wait_sel     (wait_sel),
        .internal_acc (req_internal),
        .slow_clk     (clk_slow),
        .pairs        (pairs)
    );

    ebc_region_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr         (req_addr),
        .internal_acc (req_internal),
        .low_map      (ce0_low_map),
        .ce_sel       (ce_sel_d)
    );

    ebc_seq #(.WSEL_W(WSEL_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .pairs_in (pairs),
        .state    (state),
        .enter_t4 (enter_t4)
    );

    // Request latch and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            wdata_q    <= '0;
            rdata_q    <= '0;
            write_q    <= 1'b0;
            internal_q <= 1'b0;
            ce_sel_q   <= '0;
        end else begin
            if (start) begin
                addr_q     <= req_addr;
                wdata_q    <= req_wdata;
                write_q    <= req_write;
                internal_q <= req_internal;
                ce_sel_q   <= ce_sel_d;
            end
            if (enter_t4 && !write_q && !internal_q)
                rdata_q <= bus_data_in;
        end
    end

    // Output decode from state
    logic cyc_active, strobe_phase, drive_phase;

    always_comb begin
        cyc_active   = 1'b0;
        strobe_phase = 1'b0;
        drive_phase  = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE: ;
            ST_T1: cyc_active = 1'b1;
            ST_T2, ST_T3, ST_TW1, ST_TW2: begin
                cyc_active   = 1'b1;
                strobe_phase = 1'b1;
                drive_phase  = 1'b1;
            end
            ST_T4: begin
                cyc_active  = 1'b1;
                drive_phase = 1'b1;
            end
        endcase
        bus_addr     = addr_q;
        bus_ce_n     = ~(ce_sel_q & {3{cyc_active && !standby}});
        bus_rd_n     = !(strobe_phase && !write_q && !internal_q);
        bus_wr_n     = !(strobe_phase && write_q && !internal_q);
        bus_data_oe  = drive_phase && write_q && !internal_q;
        bus_data_out = wdata_q;
        rd_data      = rdata_q;
        done         = (state == ST_DONE);
        busy         = (state != ST_IDLE);
    end

    assert_one_ce_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~bus_ce_n) <= 1);
    assert_standby_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (&bus_ce_n));
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));
    assert_t4_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T4) |-> (bus_rd_n && bus_wr_n));
    assert_internal_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && internal_q) |-> ((&bus_ce_n) && bus_rd_n && bus_wr_n && !bus_data_oe));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$rose(busy) && !done) |-> $stable(bus_addr));
endmodule

// File: tb/sim_ext_bus_ctrl.sv
`timescale 1ns/1ps
module sim_ext_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [21:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        req_internal = 1'b0;
    logic        clk_slow = 1'b0;
    logic        standby = 1'b0;
    logic [2:0]  wait_sel = '0;
    logic        ce0_low_map = 1'b0;
    logic [7:0]  bus_data_in = '0;
    logic [21:0] bus_addr;
    logic [2:0]  bus_ce_n;
    logic        bus_rd_n, bus_wr_n, bus_data_oe, done, busy;
    logic [7:0]  bus_data_out, rd_data;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    ext_bus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_internal(req_internal),
        .clk_slow(clk_slow), .standby(standby), .wait_sel(wait_sel),
        .ce0_low_map(ce0_low_map), .bus_data_in(bus_data_in), .bus_addr(bus_addr),
        .bus_ce_n(bus_ce_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe), .rd_data(rd_data),
        .done(done), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Results of the last access
    int n_cyc, rd_low, wr_low, oe_good, oe_bad, addr_bad, extra_done;
    int ce_low[3];
    bit t1_hi, t4_hi, dbl_strobe;

    task automatic access(input logic [21:0] a, input bit wr, input logic [7:0] wd,
                          input bit intl, input bit slow, input logic [2:0] sel,
                          input bit lowmap, input bit sb, input logic [7:0] rdv,
                          input bit poke);
        @(negedge clk);
        req_addr = a; req_write = wr; req_wdata = wd; req_internal = intl;
        clk_slow = slow; wait_sel = sel; ce0_low_map = lowmap; standby = sb;
        bus_data_in = rdv; req_valid = 1'b1;
        n_cyc = 0; rd_low = 0; wr_low = 0; oe_good = 0; oe_bad = 0; addr_bad = 0;
        extra_done = 0; ce_low = '{0, 0, 0}; t1_hi = 0; t4_hi = 0; dbl_strobe = 0;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (done) break;
            if (poke && i == 1) begin
                req_valid = 1'b1; req_addr = 22'h2F0000;
            end else begin
                req_valid = 1'b0;
            end
            if (bus_addr != a) addr_bad++;
            if (!bus_rd_n) rd_low++;
            if (!bus_wr_n) wr_low++;
            if (!bus_rd_n && !bus_wr_n) dbl_strobe = 1;
            for (int k = 0; k < 3; k++) if (!bus_ce_n[k]) ce_low[k]++;
            if (i == 0) t1_hi = bus_rd_n && bus_wr_n && !bus_data_oe;
            if (bus_data_oe && bus_data_out == wd) oe_good++;
            else if (bus_data_oe) oe_bad++;
            n_cyc++;
            @(negedge clk);
            // T4 reached once strobe released after being active
            if (!done && bus_rd_n && bus_wr_n && n_cyc >= 3) begin
                t4_hi = 1;
                bus_data_in = ~rdv;
            end
        end
        req_valid = 1'b0;
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            if (done || busy) extra_done++;
        end
    endtask

    function automatic int ce_idx_exp(input logic [21:0] a, input bit lowmap);
        if (a >= 22'h100000 && a <= 22'h1FFFFF) return 1;
        if (a >= 22'h200000 && a <= 22'h2FFFFF) return 2;
        if (!lowmap && a >= 22'h300000) return 0;
        if (lowmap && (a <= 22'h00D7FF || (a >= 22'h010000 && a <= 22'h0FFFFF))) return 0;
        return -1;
    endfunction

    task automatic test_reset();
        chk(!busy && !done, "R12 idle", busy, 0);
        chk(bus_rd_n && bus_wr_n, "R12 strobes", {bus_rd_n, bus_wr_n}, 3);
        chk(bus_ce_n == 3'b111 && !bus_data_oe, "R12 ce/oe", bus_ce_n, 7);
    endtask

    task automatic test_wait_table();
        for (int s = 0; s < 8; s++) begin
            access(22'h150000, 1'b0, 8'h00, 0, 0, 3'(s), 0, 0, 8'hA5 ^ 8'(s), 0);
            chk(rd_low == 2 + 2*s, "R1 read strobe length", rd_low, 2 + 2*s);
            chk(n_cyc == 4 + 2*s, "R2 T1..T4 length", n_cyc, 4 + 2*s);
            chk(ce_low[1] == 4 + 2*s && ce_low[0] == 0 && ce_low[2] == 0,
                "R5 CE1 span", ce_low[1], 4 + 2*s);
            chk(t1_hi && t4_hi && addr_bad == 0 && !dbl_strobe, "R2 T1/T4 strobe high",
                addr_bad, 0);
            chk(rd_data == (8'hA5 ^ 8'(s)), "R8 capture at T4 entry", rd_data, 8'hA5 ^ 8'(s));
            chk(extra_done == 0, "R10 done single pulse", extra_done, 0);
        end
    endtask

    task automatic test_write();
        access(22'h2ABCDE, 1'b1, 8'h3C, 0, 0, 3'd3, 0, 0, 8'h00, 0);
        chk(wr_low == 8 && rd_low == 0, "R1 write strobe length", wr_low, 8);
        chk(oe_good == 9 && oe_bad == 0 && t1_hi, "R9 write data T2..T4", oe_good, 9);
        chk(ce_low[2] == 10, "R5 CE2 span", ce_low[2], 10);
    endtask

    task automatic test_internal();
        access(22'h00E000, 1'b1, 8'h77, 1, 0, 3'd7, 1, 0, 8'h00, 0);
        chk(n_cyc == 4, "R3 internal no waits", n_cyc, 4);
        chk(rd_low + wr_low + ce_low[0] + ce_low[1] + ce_low[2] + oe_good + oe_bad == 0,
            "R3 internal quiet", wr_low, 0);
        access(22'h150000, 1'b0, 8'h00, 1, 0, 3'd5, 0, 0, 8'h11, 0);
        chk(rd_low == 0 && ce_low[1] == 0, "R3 internal read quiet", rd_low, 0);
    endtask

    task automatic test_slow();
        access(22'h350000, 1'b0, 8'h00, 0, 1, 3'd7, 0, 0, 8'h5A, 0);
        chk(rd_low == 2 && n_cyc == 4, "R4 slow clock no waits", rd_low, 2);
        chk(rd_data == 8'h5A, "R4 slow read data", rd_data, 8'h5A);
    endtask

    task automatic test_decode();
        logic [21:0] addrs[10] = '{22'h350000, 22'h001000, 22'h001000, 22'h00D7FF,
                                   22'h00D800, 22'h010000, 22'h350000, 22'h0FFFFF,
                                   22'h1FFFFF, 22'h200000};
        bit maps[10] = '{0, 0, 1, 1, 1, 1, 1, 1, 0, 1};
        for (int i = 0; i < 10; i++) begin
            int e;
            e = ce_idx_exp(addrs[i], maps[i]);
            access(addrs[i], 1'b0, 8'h00, 0, 0, 3'd0, maps[i], 0, 8'h22, 0);
            for (int k = 0; k < 3; k++)
                chk(ce_low[k] == ((k == e) ? 4 : 0), "R6 chip enable map", ce_low[k],
                    (k == e) ? 4 : 0);
            chk(rd_low == 2, "R6 unmapped still strobes", rd_low, 2);
        end
    endtask

    task automatic test_standby();
        access(22'h150000, 1'b0, 8'h00, 0, 0, 3'd2, 0, 1, 8'h44, 0);
        chk(ce_low[0] + ce_low[1] + ce_low[2] == 0, "R7 standby forces CE high",
            ce_low[1], 0);
        standby = 1'b0;
    endtask

    task automatic test_busy_ignore();
        access(22'h120000, 1'b0, 8'h00, 0, 0, 3'd1, 0, 0, 8'h99, 1);
        chk(n_cyc == 6 && extra_done == 0, "R10 request while busy ignored",
            extra_done, 0);
        chk(ce_low[2] == 0 && ce_low[1] == 6, "R11 single enable", ce_low[2], 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_wait_table();
        test_write();
        test_internal();
        test_slow();
        test_decode();
        test_standby();
        test_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule